// File: doc/BRIEF.md
# Shared Register Mailbox Handshake Controller

Two processors exchange data through a bank of fifteen shared data registers: a host on one port, and a local processor on the other. Neither side rings a doorbell. The hand-off is signalled by side effects of ordinary accesses. Touching the last data register (index 14) marks a write as complete or a read as done. Touching the first data register (index 0) moves a ready line that paces the host. Index 15 on either port selects a control/status word. That word shows two write-complete flags, an interrupt enable, a ready-pacing enable and a flag that tracks whether the host has written more recently than the local side.

The block produces two outputs. The first is a ready signal for the host. The second is an interrupt request to the local processor, raised when the host has finished a write and the interrupt is enabled. A mode input states whether the device runs as a bus slave to the host. Outside that mode, ready pacing is inert. All state updates land on the rising clock edge at which the access strobe is sampled. Read data is combinational from the current index.

Top module: `mbx_handshake`

## Requirements
- R1: After synchronous reset, all fifteen data registers are zero and every control bit is zero. The ready output `rdy` is 1 and `mwe_irq` is 0.
- R2: Indices 0 to 14 address the data registers and index 15 addresses the control/status word. A write takes effect at the clock edge at which the strobe is sampled. Read data follows the index combinationally. When both ports write the same data register in one cycle, the register keeps the host (master) value.
- R3: The host-write-done flag (status bit 7) sets when the host writes register 14 and clears when the local side reads register 14. If both happen in one cycle, the flag ends up set.
- R4: The local-write-done flag (status bit 5) sets when the local side writes register 14 and clears when the host reads register 14. If both happen in one cycle, the flag ends up set.
- R5: `mwe_irq` is 1 exactly when status bit 7 and the interrupt enable (status bit 6) are both 1.
- R6: The status word has the following layout: bit 7 is host-write-done, bit 6 is the interrupt enable, bit 5 is local-write-done, bit 4 is the ready-pacing enable, bit 3 is host-write-mode, and bits 2..0 read as 0. A local-side write to index 15 loads bits 6 and 4 only. A host write to index 15 changes nothing.
- R7: Host-write-mode (status bit 3) sets on any host write to registers 0 to 14 and clears on any local-side write to registers 0 to 14. If both happen in one cycle, it ends up set.
- R8: With pacing enabled and slave mode on, `rdy` goes to 0 in the cycle after one of two events: a local read of register 0 while host-write-mode is 1, or a local write of register 14.
- R9: With pacing enabled and slave mode on, `rdy` goes to 1 in the cycle after any of these events: a host read of register 14, a host read of index 15, or a write to register 0 from either port. If a low-going event occurs in the same cycle, `rdy` goes to 0.
- R10: When pacing is disabled or slave mode is off, `rdy` keeps its level whatever accesses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_mode | input | 1 | 1 when the device runs as a bus slave to the host |
| m_idx | input | 4 | Host register index (15 = status word) |
| m_rd | input | 1 | Host read strobe |
| m_wr | input | 1 | Host write strobe |
| m_wdata | input | 8 | Host write data |
| m_rdata | output | 8 | Host read data |
| s_idx | input | 4 | Local register index (15 = status word) |
| s_rd | input | 1 | Local read strobe |
| s_wr | input | 1 | Local write strobe |
| s_wdata | input | 8 | Local write data |
| s_rdata | output | 8 | Local read data |
| rdy | output | 1 | Ready line to the host |
| mwe_irq | output | 1 | Host-write-done interrupt to the local processor |

## Verification
The bound checker tests the following on every clock: that writing register 14 always leaves the matching done flag set, that the interrupt never rises without both of its conditions, that a local write of register 14 pulls `rdy` low while pacing is armed, that `rdy` is frozen while pacing is disarmed, that host writes to the status word are inert, and that the reset state is correct. Several behaviours can only be seen through the bench's scenarios and its cycle-by-cycle model: master priority on a shared-register collision, low-over-high resolution on `rdy`, the clears of the flags, and host-write-mode gating the register-0 read event.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 15;

    // status word bit positions
    localparam int CSR_MWEF = 7;
    localparam int CSR_IEN  = 6;
    localparam int CSR_SWEF = 5;
    localparam int CSR_ACK  = 4;
    localparam int CSR_MWM  = 3;

    typedef struct packed {
        logic mwef;
        logic ien;
        logic swef;
        logic ack_en;
        logic mwm;
    } ctl_t;

    typedef struct packed {
        logic m_wr_last;
        logic m_rd_last;
        logic m_rd_csr;
        logic m_wr_first;
        logic m_wr_data;
        logic s_wr_last;
        logic s_rd_last;
        logic s_rd_first;
        logic s_wr_first;
        logic s_wr_data;
        logic s_wr_csr;
    } evt_t;

    function automatic logic [DATA_W-1:0] pack_csr(ctl_t c);
        logic [DATA_W-1:0] v;
        v           = '0;
        v[CSR_MWEF] = c.mwef;
        v[CSR_IEN]  = c.ien;
        v[CSR_SWEF] = c.swef;
        v[CSR_ACK]  = c.ack_en;
        v[CSR_MWM]  = c.mwm;
        return v;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    parameter int IW   = $clog2(NREG + 1)
) (
    input  logic [IW-1:0] m_idx,
    input  logic          m_rd,
    input  logic          m_wr,
    input  logic [IW-1:0] s_idx,
    input  logic          s_rd,
    input  logic          s_wr,
    output evt_t          evt
);
    localparam logic [IW-1:0] FIRST = '0;
    localparam logic [IW-1:0] LAST  = IW'(NREG - 1);
    localparam logic [IW-1:0] CSR   = IW'(NREG);

    always_comb begin
        evt.m_wr_last  = m_wr && (m_idx == LAST);
        evt.m_rd_last  = m_rd && (m_idx == LAST);
        evt.m_rd_csr   = m_rd && (m_idx == CSR);
        evt.m_wr_first = m_wr && (m_idx == FIRST);
        evt.m_wr_data  = m_wr && (m_idx < CSR);
        evt.s_wr_last  = s_wr && (s_idx == LAST);
        evt.s_rd_last  = s_rd && (s_idx == LAST);
        evt.s_rd_first = s_rd && (s_idx == FIRST);
        evt.s_wr_first = s_wr && (s_idx == FIRST);
        evt.s_wr_data  = s_wr && (s_idx < CSR);
        evt.s_wr_csr   = s_wr && (s_idx == CSR);
    end
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile #(
    parameter int DW   = 8,
    parameter int NREG = 15,
    parameter int IW   = $clog2(NREG + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] m_idx,
    input  logic          m_wr,
    input  logic [DW-1:0] m_wdata,
    input  logic [IW-1:0] s_idx,
    input  logic          s_wr,
    input  logic [DW-1:0] s_wdata,
    output logic [DW-1:0] m_dout,
    output logic [DW-1:0] s_dout
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (m_wr && (m_idx == IW'(g)))
                regs[g] <= m_wdata;          // host wins a collision
            else if (s_wr && (s_idx == IW'(g)))
                regs[g] <= s_wdata;
        end
    end

    always_comb begin
        m_dout = '0;
        s_dout = '0;
        for (int i = 0; i < NREG; i++) begin
            if (m_idx == IW'(i)) m_dout = regs[i];
            if (s_idx == IW'(i)) s_dout = regs[i];
        end
    end
endmodule

// File: rtl/mbx_ctl.sv
module mbx_ctl
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic m_wr_last,
    input  logic m_rd_last,
    input  logic m_wr_data,
    input  logic s_wr_last,
    input  logic s_rd_last,
    input  logic s_wr_data,
    input  logic s_wr_csr,
    input  logic ien_wbit,
    input  logic ack_wbit,
    output ctl_t ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            // set events dominate clear events
            ctl.mwef <= m_wr_last | (ctl.mwef & ~s_rd_last);
            ctl.swef <= s_wr_last | (ctl.swef & ~m_rd_last);
            ctl.mwm  <= m_wr_data | (ctl.mwm & ~s_wr_data);
            if (s_wr_csr) begin
                ctl.ien    <= ien_wbit;
                ctl.ack_en <= ack_wbit;
            end
        end
    end
endmodule

// File: rtl/mbx_ready.sv
module mbx_ready (
    input  logic clk,
    input  logic rst,
    input  logic slave_mode,
    input  logic ack_en,
    input  logic mwm,
    input  logic m_rd_last,
    input  logic m_rd_csr,
    input  logic m_wr_first,
    input  logic s_wr_last,
    input  logic s_rd_first,
    input  logic s_wr_first,
    output logic rdy
);
    logic armed, go_lo, go_hi;

    always_comb begin
        armed = slave_mode & ack_en;
        go_lo = armed & (s_wr_last | (s_rd_first & mwm));
        go_hi = armed & (m_rd_last | m_rd_csr | m_wr_first | s_wr_first);
    end

    always_ff @(posedge clk) begin
        if (rst)        rdy <= 1'b1;
        else if (go_lo) rdy <= 1'b0;
        else if (go_hi) rdy <= 1'b1;
    end
endmodule

// File: rtl/mbx_handshake.sv
module mbx_handshake
    import mbx_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int NREG = NUM_REGS,
    parameter int IW   = $clog2(NREG + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          slave_mode,
    input  logic [IW-1:0] m_idx,
    input  logic          m_rd,
    input  logic          m_wr,
    input  logic [DW-1:0] m_wdata,
    output logic [DW-1:0] m_rdata,
    input  logic [IW-1:0] s_idx,
    input  logic          s_rd,
    input  logic          s_wr,
    input  logic [DW-1:0] s_wdata,
    output logic [DW-1:0] s_rdata,
    output logic          rdy,
    output logic          mwe_irq
);
    localparam logic [IW-1:0] CSR = IW'(NREG);

    evt_t          evt;
    ctl_t          ctl_q;
    logic [DW-1:0] m_dout, s_dout, csr_word;

    mbx_decode #(.NREG(NREG), .IW(IW)) u_dec (
        .m_idx(m_idx), .m_rd(m_rd), .m_wr(m_wr),
        .s_idx(s_idx), .s_rd(s_rd), .s_wr(s_wr),
        .evt(evt)
    );

    mbx_regfile #(.DW(DW), .NREG(NREG), .IW(IW)) u_rf (
        .clk(clk), .rst(rst),
        .m_idx(m_idx), .m_wr(m_wr), .m_wdata(m_wdata),
        .s_idx(s_idx), .s_wr(s_wr), .s_wdata(s_wdata),
        .m_dout(m_dout), .s_dout(s_dout)
    );

    mbx_ctl u_ctl (
        .clk(clk), .rst(rst),
        .m_wr_last(evt.m_wr_last), .m_rd_last(evt.m_rd_last),
        .m_wr_data(evt.m_wr_data), .s_wr_last(evt.s_wr_last),
        .s_rd_last(evt.s_rd_last), .s_wr_data(evt.s_wr_data),
        .s_wr_csr(evt.s_wr_csr),
        .ien_wbit(s_wdata[CSR_IEN]), .ack_wbit(s_wdata[CSR_ACK]),
        .ctl(ctl_q)
    );

    mbx_ready u_rdy (
        .clk(clk), .rst(rst), .slave_mode(slave_mode),
        .ack_en(ctl_q.ack_en), .mwm(ctl_q.mwm),
        .m_rd_last(evt.m_rd_last), .m_rd_csr(evt.m_rd_csr),
        .m_wr_first(evt.m_wr_first), .s_wr_last(evt.s_wr_last),
        .s_rd_first(evt.s_rd_first), .s_wr_first(evt.s_wr_first),
        .rdy(rdy)
    );

    always_comb begin
        csr_word = DW'(pack_csr(ctl_q));
        m_rdata  = (m_idx == CSR) ? csr_word : m_dout;
        s_rdata  = (s_idx == CSR) ? csr_word : s_dout;
        mwe_irq  = ctl_q.mwef & ctl_q.ien;
    end
endmodule

// File: rtl/mbx_handshake_chk.sv
module mbx_handshake_chk
    import mbx_pkg::*;
#(
    parameter int NREG = NUM_REGS,
    parameter int IW   = $clog2(NREG + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          slave_mode,
    input logic [IW-1:0] m_idx,
    input logic          m_wr,
    input logic [IW-1:0] s_idx,
    input logic          s_wr,
    input logic          rdy,
    input logic          mwe_irq,
    input ctl_t          ctl
);
    localparam logic [IW-1:0] LAST = IW'(NREG - 1);
    localparam logic [IW-1:0] CSR  = IW'(NREG);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (rdy && !mwe_irq && ctl == '0));

    p_mwef_set_r3: assert property (@(posedge clk) disable iff (rst)
        (m_wr && m_idx == LAST) |=> ctl.mwef);

    p_swef_set_r4: assert property (@(posedge clk) disable iff (rst)
        (s_wr && s_idx == LAST) |=> ctl.swef);

    p_irq_gate_r5: assert property (@(posedge clk) disable iff (rst)
        mwe_irq |-> (ctl.mwef && ctl.ien));

    p_host_csr_inert_r6: assert property (@(posedge clk) disable iff (rst)
        (m_wr && m_idx == CSR && !(s_wr && s_idx == CSR))
            |=> ($stable(ctl.ien) && $stable(ctl.ack_en)));

    p_rdy_low_r8: assert property (@(posedge clk) disable iff (rst)
        (slave_mode && ctl.ack_en && s_wr && s_idx == LAST) |=> !rdy);

    p_rdy_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!slave_mode || !ctl.ack_en) |=> $stable(rdy));
endmodule

bind mbx_handshake mbx_handshake_chk #(.NREG(NREG), .IW(IW)) u_chk (
    .clk(clk), .rst(rst), .slave_mode(slave_mode),
    .m_idx(m_idx), .m_wr(m_wr), .s_idx(s_idx), .s_wr(s_wr),
    .rdy(rdy), .mwe_irq(mwe_irq), .ctl(ctl_q)
);

// File: tb/mbx_handshake_bench.sv
module mbx_handshake_bench;
    localparam int CLK_P = 10;
    localparam int DW    = 8;
    localparam int NREG  = 15;
    localparam int IW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          slave_mode = 1'b1;
    logic [IW-1:0] m_idx = '0, s_idx = '0;
    logic          m_rd = 1'b0, m_wr = 1'b0, s_rd = 1'b0, s_wr = 1'b0;
    logic [DW-1:0] m_wdata = '0, s_wdata = '0;
    logic [DW-1:0] m_rdata, s_rdata;
    logic          rdy, mwe_irq;

    mbx_handshake u_mbx_handshake (
        .clk(clk), .rst(rst), .slave_mode(slave_mode),
        .m_idx(m_idx), .m_rd(m_rd), .m_wr(m_wr), .m_wdata(m_wdata), .m_rdata(m_rdata),
        .s_idx(s_idx), .s_rd(s_rd), .s_wr(s_wr), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .rdy(rdy), .mwe_irq(mwe_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference model
    int  mem [NREG];
    bit  md_mwef = 0, md_ien = 0, md_swef = 0, md_ack = 0, md_mwm = 0, md_rdy = 1;
    bit  lo, hi;

    always @(posedge clk) begin
        if (rst) begin
            foreach (mem[i]) mem[i] = 0;
            md_mwef = 0; md_ien = 0; md_swef = 0; md_ack = 0; md_mwm = 0; md_rdy = 1;
        end else begin
            lo = md_ack && slave_mode &&
                 ((s_rd && s_idx == 0 && md_mwm) || (s_wr && s_idx == 14));
            hi = md_ack && slave_mode &&
                 ((m_rd && (m_idx == 14 || m_idx == 15)) ||
                  (m_wr && m_idx == 0) || (s_wr && s_idx == 0));
            if (lo) md_rdy = 0; else if (hi) md_rdy = 1;
            if (m_wr && m_idx == 14) md_mwef = 1; else if (s_rd && s_idx == 14) md_mwef = 0;
            if (s_wr && s_idx == 14) md_swef = 1; else if (m_rd && m_idx == 14) md_swef = 0;
            if (m_wr && m_idx < 15) md_mwm = 1; else if (s_wr && s_idx < 15) md_mwm = 0;
            if (s_wr && s_idx == 15) begin
                md_ien = s_wdata[6];
                md_ack = s_wdata[4];
            end
            if (s_wr && s_idx < 15) mem[s_idx] = int'(s_wdata);
            if (m_wr && m_idx < 15) mem[m_idx] = int'(m_wdata);
        end
    end

    function automatic int model_read(logic [IW-1:0] idx);
        if (idx == 15)
            return (int'(md_mwef) << 7) | (int'(md_ien) << 6) | (int'(md_swef) << 5) |
                   (int'(md_ack) << 4) | (int'(md_mwm) << 3);
        return mem[idx];
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic compare_all();
        chk("R8/R9/R10", "rdy", int'(rdy), int'(md_rdy));
        chk("R5", "mwe_irq", int'(mwe_irq), int'(md_mwef && md_ien));
        chk("R2/R6", "m_rdata", int'(m_rdata), model_read(m_idx));
        chk("R2/R6", "s_rdata", int'(s_rdata), model_read(s_idx));
    endtask

    task automatic cyc();
        @(posedge clk);
        #(CLK_P/4);
        compare_all();
    endtask

    task automatic idle();
        m_rd = 0; m_wr = 0; s_rd = 0; s_wr = 0;
    endtask

    task automatic peek(input logic [IW-1:0] idx, output int val);
        m_idx = idx; m_rd = 0; m_wr = 0;
        #1;
        val = int'(m_rdata);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int v;
        idle();
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        rst = 0;
        // R1 reset state
        chk("R1", "rdy after reset", int'(rdy), 1);
        chk("R1", "irq after reset", int'(mwe_irq), 0);
        peek(4'd15, v); chk("R1", "status after reset", v, 0);
        peek(4'd7, v);  chk("R1", "reg7 after reset", v, 0);

        // R6 local side loads bits 6 and 4 only
        s_idx = 15; s_wdata = 8'hFF; s_wr = 1; cyc(); idle();
        peek(4'd15, v); chk("R6", "status after local write", v, 8'h50);
        // R6 host write to status is inert
        m_idx = 15; m_wdata = 8'h00; m_wr = 1; cyc(); idle();
        peek(4'd15, v); chk("R6", "status after host write", v, 8'h50);

        // R3 R5 R7 host writes last register
        m_idx = 14; m_wdata = 8'hA5; m_wr = 1; cyc(); idle();
        chk("R5", "irq raised", int'(mwe_irq), 1);
        peek(4'd15, v); chk("R3", "host done flag and mode (R7)", v, 8'hD8);

        // R8 local read of reg0 in host-write-mode
        s_idx = 0; s_rd = 1; cyc(); idle();
        chk("R8", "rdy low after local read 0", int'(rdy), 0);
        // R9 host write of reg0
        m_idx = 0; m_wdata = 8'h11; m_wr = 1; cyc(); idle();
        chk("R9", "rdy high after host write 0", int'(rdy), 1);

        // R2 collision: master wins
        m_idx = 3; m_wdata = 8'h33; m_wr = 1;
        s_idx = 3; s_wdata = 8'h44; s_wr = 1; cyc(); idle();
        peek(4'd3, v); chk("R2", "collision value", v, 8'h33);

        // R3 set beats clear
        s_idx = 14; s_rd = 1; m_idx = 14; m_wdata = 8'h5A; m_wr = 1; cyc(); idle();
        peek(4'd15, v); chk("R3", "host flag kept on conflict", v, 8'hD8);

        // R4 R9 R7: local writes 14 while host reads status
        s_idx = 14; s_wdata = 8'h77; s_wr = 1; m_idx = 15; m_rd = 1; cyc(); idle();
        chk("R9", "low wins over high", int'(rdy), 0);
        peek(4'd15, v); chk("R4", "local flag set, mode cleared (R7)", v, 8'hF0);

        // R4 host reads 14 clears local flag, rdy high
        m_idx = 14; m_rd = 1; cyc(); idle();
        chk("R9", "rdy high on host read 14", int'(rdy), 1);
        peek(4'd15, v); chk("R4", "local flag cleared", v, 8'hD0);

        // R5 local reads 14 clears host flag, irq drops
        s_idx = 14; s_rd = 1; cyc(); idle();
        chk("R5", "irq dropped", int'(mwe_irq), 0);

        // R10 non-slave mode freezes rdy
        s_idx = 14; s_wr = 1; cyc(); idle();
        chk("R8", "rdy low after local write 14", int'(rdy), 0);
        slave_mode = 0;
        m_idx = 0; m_wr = 1; cyc(); idle();
        chk("R10", "rdy held in non-slave mode", int'(rdy), 0);
        slave_mode = 1;
        // R10 pacing disabled freezes rdy
        s_idx = 15; s_wdata = 8'h40; s_wr = 1; cyc(); idle();
        m_idx = 0; m_wr = 1; cyc(); idle();
        chk("R10", "rdy held with pacing off", int'(rdy), 0);
        // R8 read of reg0 without host-write-mode does nothing
        s_idx = 15; s_wdata = 8'h10; s_wr = 1; cyc(); idle();
        s_idx = 1; s_wdata = 8'h01; s_wr = 1; cyc(); idle();
        m_idx = 14; m_rd = 1; cyc(); idle();
        chk("R9", "rdy high again", int'(rdy), 1);
        s_idx = 0; s_rd = 1; cyc(); idle();
        chk("R8", "no low without host-write-mode", int'(rdy), 1);

        // random traffic against the model
        for (int n = 0; n < 6000; n++) begin
            m_idx   = IW'($urandom_range(0, 15));
            s_idx   = IW'($urandom_range(0, 15));
            m_rd    = ($urandom_range(0, 3) == 0);
            m_wr    = ($urandom_range(0, 3) == 0);
            s_rd    = ($urandom_range(0, 3) == 0);
            s_wr    = ($urandom_range(0, 3) == 0);
            m_wdata = DW'($urandom);
            s_wdata = DW'($urandom);
            if ($urandom_range(0, 199) == 0) slave_mode = ~slave_mode;
            cyc();
        end
        idle();
        cyc();
        finish_run();
    end
endmodule